// File: doc/BRIEF.md
# Thread Block Dispatcher

This block hands out the thread blocks of a compute grid to a small array of processing cores. A launch names how many blocks the grid has, how many threads each block holds and how many scratchpad bytes each block reserves. All blocks in one grid are the same size. The dispatcher places blocks one at a time, in ascending index order. A block goes to a core only when that core has room for it in all three resources at once: resident threads, resident block slots and scratchpad bytes.

Each core keeps a ledger of what it holds. A placed block stays on its core until the core pulses its completion line, because blocks are never preempted. The pulse returns that block's threads, slot and scratchpad to the ledger. When every block has been placed and has finished, a done flag is raised. A launch whose single block could not fit even on an empty core is refused with an error flag.

Top module: `tbd_dispatcher`

## Requirements
- R1: After reset `launch_ready` is 1, and `disp_valid`, `grid_done` and `launch_err` are 0.
- R2: Blocks are offered in ascending index order starting from 0, at most one new offer per cycle, and `disp_block` carries the index of the block being offered.
- R3: Each offer goes to the lowest-numbered core that can admit the block. Bit i of `disp_valid` being set means core i is being offered the block, and at most one bit is ever set.
- R4: The thread counts of the blocks resident on a core never sum to more than MAX_THREADS.
- R5: A core never holds more than MAX_SLOTS resident blocks.
- R6: The scratchpad bytes of the blocks on a core never sum to more than SCRATCH_BYTES. A block that asks for the whole scratchpad therefore has a core to itself.
- R7: An offer is held with the same core bit and the same block index until that core raises `disp_ready`. No other offer is made while it waits.
- R8: A one-cycle `cmpl_valid[i]` pulse releases one block's resources on core i. An offer that uses the freed space appears two cycles after the pulse is sampled, and never in the cycle right after it.
- R9: `grid_done` rises the cycle after the last block's release takes effect. It stays high until the next launch is accepted, and is never high while blocks are pending or resident.
- R10: A launch is refused when its thread count is 0 or above MAX_THREADS, or when its scratchpad bytes exceed SCRATCH_BYTES. On refusal, `launch_err` is 1 in the next cycle, no block is offered and `launch_ready` stays 1.
- R11: A launch of zero blocks raises `grid_done` one cycle after it is accepted.
- R12: `launch_ready` is 0 while a grid is running, and `launch_valid` has no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Launch request |
| launch_ready | output | 1 | Dispatcher idle and able to take a launch |
| launch_blocks | input | BLK_W | Number of blocks in the grid |
| launch_threads | input | TH_W+1 | Threads per block |
| launch_scratch | input | SC_W+1 | Scratchpad bytes per block |
| disp_valid | output | NUM_CORES | One-hot offer of a block to a core |
| disp_ready | input | NUM_CORES | Core accepts the offered block |
| disp_block | output | BLK_W | Index of the offered block |
| cmpl_valid | input | NUM_CORES | Core reports that one of its blocks finished |
| grid_done | output | 1 | Whole grid finished |
| launch_err | output | 1 | Last launch was refused |

## Verification
An accepted launch produces its first offer on the second edge after the launch edge. Each later offer is decided from the ledger state of the previous edge. A completion pulse reaches an offer after two edges, and it reaches `grid_done` after two edges when it is the final release. The bench drives at falling edges and keeps a per-core occupancy model that applies each release one falling edge after the pulse was driven. This means every comparison of `disp_valid`, `disp_block` and `grid_done` is made in exactly the cycle in which the registered outputs carry that decision. The directed tests check the single-cycle delays of refusal and done, and they check for an absent offer in the cycle after a pulse.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  // Dispatcher control state; outputs are decoded from it
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } tbd_state_e;
endpackage

// File: rtl/tbd_core_ledger.sv
// Occupancy ledger of one core: threads, block slots and scratchpad in use.
module tbd_core_ledger #(
  parameter int MAX_THREADS   = 1536,
  parameter int MAX_SLOTS     = 16,
  parameter int SCRATCH_BYTES = 49152,
  parameter int TH_W          = 11,
  parameter int SC_W          = 16,
  parameter int SL_W          = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  logic            release_i,
  input  logic [TH_W-1:0] blk_thr,
  input  logic [SC_W-1:0] blk_scr,
  output logic            fits,
  output logic            occupied
);
  logic [TH_W-1:0] thr_q;
  logic [SC_W-1:0] scr_q;
  logic [SL_W-1:0] slot_q;

  logic [TH_W:0] thr_sum;
  logic [SC_W:0] scr_sum;

  assign thr_sum  = {1'b0, thr_q} + {1'b0, blk_thr};
  assign scr_sum  = {1'b0, scr_q} + {1'b0, blk_scr};
  assign occupied = (slot_q != '0);

  // Admission needs a free slot, thread room and scratchpad room together
  assign fits = (slot_q < SL_W'(MAX_SLOTS)) &&
                (thr_sum <= (TH_W+1)'(MAX_THREADS)) &&
                (scr_sum <= (SC_W+1)'(SCRATCH_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= '0;
      scr_q  <= '0;
      slot_q <= '0;
    end else begin
      unique case ({alloc, release_i})
        2'b10: begin
          thr_q  <= thr_q + blk_thr;
          scr_q  <= scr_q + blk_scr;
          slot_q <= slot_q + 1'b1;
        end
        2'b01: begin
          thr_q  <= thr_q - blk_thr;
          scr_q  <= scr_q - blk_scr;
          slot_q <= slot_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tbd_lowest_pick.sv
// Grants the lowest-indexed requester.
module tbd_lowest_pick #(
  parameter int N = 15
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N-1:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant[i] = req[i] & ~seen[i];
    if (i < N-1) begin : g_chain
      assign seen[i+1] = seen[i] | req[i];
    end
  end
endmodule

// File: rtl/tbd_dispatcher.sv
module tbd_dispatcher
  import tbd_pkg::*;
#(
  parameter int NUM_CORES     = 15,
  parameter int MAX_THREADS   = 1536,
  parameter int MAX_SLOTS     = 16,
  parameter int SCRATCH_BYTES = 49152,
  parameter int BLK_W         = 16,
  localparam int TH_W  = $clog2(MAX_THREADS + 1),
  localparam int SC_W  = $clog2(SCRATCH_BYTES + 1),
  localparam int LT_W  = TH_W + 1,
  localparam int LS_W  = SC_W + 1,
  localparam int SL_W  = $clog2(MAX_SLOTS + 1),
  localparam int OUT_W = $clog2(NUM_CORES * MAX_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 launch_valid,
  output logic                 launch_ready,
  input  logic [BLK_W-1:0]     launch_blocks,
  input  logic [LT_W-1:0]      launch_threads,
  input  logic [LS_W-1:0]      launch_scratch,
  output logic [NUM_CORES-1:0] disp_valid,
  input  logic [NUM_CORES-1:0] disp_ready,
  output logic [BLK_W-1:0]     disp_block,
  input  logic [NUM_CORES-1:0] cmpl_valid,
  output logic                 grid_done,
  output logic                 launch_err
);
  tbd_state_e           state_q;
  logic [BLK_W-1:0]     blocks_q;
  logic [BLK_W-1:0]     next_q;
  logic [TH_W-1:0]      thr_q;
  logic [SC_W-1:0]      scr_q;
  logic [NUM_CORES-1:0] offer_q;
  logic [BLK_W-1:0]     offer_id_q;
  logic [OUT_W-1:0]     outst_q;

  logic [NUM_CORES-1:0] fit_vec, occ_vec, grant_vec, alloc_vec, rel_vec;
  logic [OUT_W-1:0]     rel_cnt;
  logic launch_fire, launch_bad, accepted, want, new_offer, finished;

  assign launch_ready = (state_q != ST_RUN);
  assign grid_done    = (state_q == ST_DONE);
  assign launch_err   = (state_q == ST_ERR);
  assign disp_valid   = offer_q;
  assign disp_block   = offer_id_q;

  assign launch_fire = launch_valid && (state_q != ST_RUN);
  assign launch_bad  = (launch_threads == '0) ||
                       (launch_threads > LT_W'(MAX_THREADS)) ||
                       (launch_scratch > LS_W'(SCRATCH_BYTES));

  assign accepted  = |(offer_q & disp_ready);
  assign want      = (state_q == ST_RUN) && (next_q != blocks_q) &&
                     ((offer_q == '0) || accepted);
  assign new_offer = want && (|fit_vec);
  assign alloc_vec = new_offer ? grant_vec : '0;
  assign rel_vec   = cmpl_valid & occ_vec;
  assign finished  = (state_q == ST_RUN) && (next_q == blocks_q) &&
                     (outst_q == '0) && (offer_q == '0);

  always_comb begin
    rel_cnt = '0;
    for (int i = 0; i < NUM_CORES; i++) rel_cnt = rel_cnt + OUT_W'(rel_vec[i]);
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    tbd_core_ledger #(
      .MAX_THREADS  (MAX_THREADS),
      .MAX_SLOTS    (MAX_SLOTS),
      .SCRATCH_BYTES(SCRATCH_BYTES),
      .TH_W         (TH_W),
      .SC_W         (SC_W),
      .SL_W         (SL_W)
    ) u_ledger (
      .clk      (clk),
      .rst      (rst),
      .alloc    (alloc_vec[c]),
      .release_i(rel_vec[c]),
      .blk_thr  (thr_q),
      .blk_scr  (scr_q),
      .fits     (fit_vec[c]),
      .occupied (occ_vec[c])
    );
  end

  tbd_lowest_pick #(.N(NUM_CORES)) u_pick (
    .req  (fit_vec),
    .grant(grant_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      blocks_q   <= '0;
      next_q     <= '0;
      thr_q      <= '0;
      scr_q      <= '0;
      offer_q    <= '0;
      offer_id_q <= '0;
      outst_q    <= '0;
    end else begin
      outst_q <= outst_q + OUT_W'(new_offer) - rel_cnt;
      if (launch_fire) begin
        if (launch_bad) begin
          state_q <= ST_ERR;
        end else begin
          state_q  <= ST_RUN;
          blocks_q <= launch_blocks;
          next_q   <= '0;
          thr_q    <= launch_threads[TH_W-1:0];
          scr_q    <= launch_scratch[SC_W-1:0];
        end
      end else if (finished) begin
        state_q <= ST_DONE;
      end
      if (new_offer) begin
        offer_q    <= grant_vec;
        offer_id_q <= next_q;
        next_q     <= next_q + 1'b1;
      end else if (accepted) begin
        offer_q <= '0;
      end
    end
  end
endmodule

// File: rtl/tbd_dispatcher_chk.sv
module tbd_dispatcher_chk #(
  parameter int NUM_CORES     = 15,
  parameter int MAX_THREADS   = 1536,
  parameter int SCRATCH_BYTES = 49152,
  parameter int BLK_W         = 16,
  parameter int LT_W          = 12,
  parameter int LS_W          = 17
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 launch_valid,
  input logic                 launch_ready,
  input logic [LT_W-1:0]      launch_threads,
  input logic [LS_W-1:0]      launch_scratch,
  input logic [NUM_CORES-1:0] disp_valid,
  input logic [NUM_CORES-1:0] disp_ready,
  input logic [BLK_W-1:0]     disp_block,
  input logic                 grid_done,
  input logic                 launch_err
);
  a_r3_single_core_offer: assert property (@(posedge clk) disable iff (rst)
    $onehot0(disp_valid));

  a_r7_offer_held: assert property (@(posedge clk) disable iff (rst)
    (|(disp_valid & ~disp_ready)) |=> ($stable(disp_valid) && $stable(disp_block)));

  a_r10_refusal: assert property (@(posedge clk) disable iff (rst)
    (launch_valid && launch_ready &&
     ((launch_threads == '0) || (launch_threads > LT_W'(MAX_THREADS)) ||
      (launch_scratch > LS_W'(SCRATCH_BYTES))))
    |=> (launch_err && launch_ready && (disp_valid == '0)));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    grid_done |-> ((disp_valid == '0) && launch_ready && !launch_err));

  a_r12_running_flags: assert property (@(posedge clk) disable iff (rst)
    !launch_ready |-> (!grid_done && !launch_err));
endmodule

bind tbd_dispatcher tbd_dispatcher_chk #(
  .NUM_CORES    (NUM_CORES),
  .MAX_THREADS  (MAX_THREADS),
  .SCRATCH_BYTES(SCRATCH_BYTES),
  .BLK_W        (BLK_W),
  .LT_W         (LT_W),
  .LS_W         (LS_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .launch_valid  (launch_valid),
  .launch_ready  (launch_ready),
  .launch_threads(launch_threads),
  .launch_scratch(launch_scratch),
  .disp_valid    (disp_valid),
  .disp_ready    (disp_ready),
  .disp_block    (disp_block),
  .grid_done     (grid_done),
  .launch_err    (launch_err)
);

// File: tb/tbd_dispatcher_test.sv
`timescale 1ns/1ps
module tbd_dispatcher_test;
  localparam int NC = 3;
  localparam int MT = 256;
  localparam int MS = 3;
  localparam int SB = 1024;
  localparam int BW = 8;
  localparam int LT = $clog2(MT + 1) + 1;
  localparam int LS = $clog2(SB + 1) + 1;

  // blocks, threads, scratch, expected blocks per core, refused
  localparam int unsigned TBL [8][5] = '{
    '{7, 128,    0, 2, 0},
    '{8,  32,  100, 3, 0},
    '{5,  16, 1024, 1, 0},
    '{4,  64,  400, 2, 0},
    '{0,  16,    0, 0, 0},
    '{3, 300,    0, 0, 1},
    '{3,  16, 2000, 0, 1},
    '{3,   0,    0, 0, 1}
  };
  localparam string TAGS [8] = '{"R4", "R5", "R6", "R6", "R11", "R10", "R10", "R10"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic launch_valid = 1'b0;
  logic launch_ready;
  logic [BW-1:0] launch_blocks = '0;
  logic [LT-1:0] launch_threads = '0;
  logic [LS-1:0] launch_scratch = '0;
  logic [NC-1:0] disp_valid;
  logic [NC-1:0] disp_ready = '1;
  logic [BW-1:0] disp_block;
  logic [NC-1:0] cmpl_valid = '0;
  logic grid_done, launch_err;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  tbd_dispatcher #(
    .NUM_CORES(NC), .MAX_THREADS(MT), .MAX_SLOTS(MS),
    .SCRATCH_BYTES(SB), .BLK_W(BW)
  ) uut (
    .clk(clk), .rst(rst), .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blocks(launch_blocks), .launch_threads(launch_threads),
    .launch_scratch(launch_scratch), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_block(disp_block), .cmpl_valid(cmpl_valid), .grid_done(grid_done),
    .launch_err(launch_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_launch(input int nb, input int thr, input int scr);
    @(negedge clk);
    launch_valid   = 1'b1;
    launch_blocks  = BW'(nb);
    launch_threads = LT'(thr);
    launch_scratch = LS'(scr);
    @(negedge clk);
    launch_valid = 1'b0;
  endtask

  task automatic run_entry(input int e);
    int nb, k, ec, pend, act, exp;
    int cnt [NC];
    int nextb;
    bit fin;
    nb = int'(TBL[e][0]);
    k  = int'(TBL[e][3]);
    do_launch(nb, int'(TBL[e][1]), int'(TBL[e][2]));
    if (TBL[e][4] != 0) begin
      act = {launch_err, launch_ready, disp_valid};
      exp = {1'b1, 1'b1, {NC{1'b0}}};
      check(act == exp, TAGS[e], act, exp);
      return;
    end
    check(launch_ready == 1'b0, "R12", launch_ready, 0);
    foreach (cnt[c]) cnt[c] = 0;
    nextb = 0;
    pend  = -1;
    fin   = (nb == 0);
    for (int cyc = 0; cyc < 500; cyc++) begin
      @(negedge clk);
      cmpl_valid = '0;
      if (fin) begin
        check(grid_done == 1'b1, (nb == 0) ? "R11" : "R9", grid_done, 1);
        @(negedge clk);
        check(grid_done && launch_ready, "R9", {grid_done, launch_ready}, 3);
        return;
      end
      ec = -1;
      if (nextb < nb)
        for (int c = 0; c < NC; c++) if (ec < 0 && cnt[c] < k) ec = c;
      act = {grid_done, disp_valid, disp_block};
      if (ec >= 0) exp = {1'b0, NC'(1 << ec), BW'(nextb)};
      else         exp = {1'b0, NC'(0), disp_block};
      // R2/R3 ordering and placement; capacity by the table tag
      check(act == exp, (ec >= 0) ? "R2/R3" : TAGS[e], act, exp);
      if (ec >= 0) begin
        cnt[ec]++;
        nextb++;
      end
      if (pend >= 0) begin
        cnt[pend]--;
        pend = -1;
      end
      if (cyc % 3 == 2) begin
        for (int c = NC - 1; c >= 0; c--)
          if (pend < 0 && cnt[c] > 0) pend = c;
        if (pend >= 0) cmpl_valid[pend] = 1'b1;
      end
      fin = (nextb == nb) && (pend < 0);
      for (int c = 0; c < NC; c++) if (cnt[c] != 0) fin = 1'b0;
    end
    check(1'b0, "R9", 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({launch_ready, disp_valid, grid_done, launch_err} == {1'b1, {NC{1'b0}}, 2'b00},
          "R1", {launch_ready, disp_valid, grid_done, launch_err}, 32);

    for (int e = 0; e < 8; e++) run_entry(e);

    // R7: offer held while the core is not ready
    disp_ready = '0;
    do_launch(2, 16, 0);
    repeat (3) @(negedge clk);
    check({disp_valid, disp_block} == {3'b001, 8'd0}, "R7", {disp_valid, disp_block}, 256);
    disp_ready = '1;
    @(negedge clk);
    check({disp_valid, disp_block} == {3'b001, 8'd1}, "R7", {disp_valid, disp_block}, 257);
    @(negedge clk);
    check(disp_valid == '0, "R2", disp_valid, 0);
    cmpl_valid = 3'b001;
    @(negedge clk);
    @(negedge clk);
    cmpl_valid = '0;
    check(grid_done == 1'b0, "R9", grid_done, 0);
    @(negedge clk);
    check(grid_done == 1'b1, "R9", grid_done, 1);

    // R8: freed space reused two cycles after the pulse; R12 launch ignored
    do_launch(4, 256, 0);
    repeat (4) @(negedge clk);
    check(disp_valid == '0, "R4", disp_valid, 0);
    cmpl_valid = 3'b010;
    @(negedge clk);
    cmpl_valid = '0;
    check(disp_valid == '0, "R8", disp_valid, 0);
    launch_valid   = 1'b1;
    launch_threads = LT'(999);
    @(negedge clk);
    launch_valid = 1'b0;
    check({disp_valid, disp_block} == {3'b010, 8'd3}, "R8", {disp_valid, disp_block}, 515);
    check(launch_err == 1'b0 && launch_ready == 1'b0, "R12", {launch_err, launch_ready}, 0);
    @(negedge clk);
    cmpl_valid = 3'b111;
    @(negedge clk);
    cmpl_valid = '0;
    check(grid_done == 1'b0, "R9", grid_done, 0);
    @(negedge clk);
    check(grid_done == 1'b1, "R9", grid_done, 1);

    summary();
  end
endmodule